// File: doc/BRIEF.md
# Cascaded Serial Control Word Router

This block sits behind the serial port of one node in a daisy chain of converter front ends. Each 16-bit word arriving from the host, or from the node before it, is examined according to the node's operating mode. A control word whose hop count is zero is written into a small local bank of configuration registers. A control word with a non-zero hop count has the count reduced by one and is passed on, either to the next node or back to the host. The serializer is outside the block, and every word is presented as a parallel word plus a one-cycle valid.

Register 0 holds the mode bits. Three modes exist. In program mode every word is a control word. In data mode input words are discarded and the configuration cannot change until reset. In mixed mode the top bit of each incoming word marks control traffic, and the top bit of every outgoing sample word is forced low to mark it as data. The node can enter mixed mode with the very first write after reset.

Control word layout:
- bit 15: control flag
- bits 14:12: hop count
- bit 11: spare, forwarded unchanged
- bits 10:8: register index
- bits 7:0: register data

Top module: `cascade_ctl_router`

## Requirements
- R1: After a synchronous active-low reset, every configuration register is zero. `mode_o` reads 2'b00 (program mode), and `wr_strobe`, `fwd_valid` and `smp_out_valid` are low.
- R2: When a control word with hop count 0 and an in-range index is accepted, the next clock raises `wr_strobe` for one cycle, with `wr_index` = bits 10:8 and `wr_data` = bits 7:0. On the same edge the register with that index, visible at `cfg_flat[8*i +: 8]`, takes the data.
- R3: When a control word with a non-zero hop count is accepted, the next clock raises `fwd_valid`. `fwd_word` carries the hop count minus one in bits 14:12, and all other bits are unchanged. No register is written.
- R4: `mode_o` is derived from register 0. Bit 0 = 0 gives program mode (2'b00) whatever bit 1 holds. Bits 1:0 = 01 give data mode (2'b01). Bits 1:0 = 11 give mixed mode (2'b11). A mode change applies from the word after the one that wrote register 0.
- R5: In mixed mode, a word with bit 15 = 1 is handled as a control word as in R2 and R3. A word with bit 15 = 0 causes no write and no forward.
- R6: A sample word presented on `smp_in_*` appears on `smp_out_*` one clock later. In mixed mode bit 15 is forced to 0; in program and data modes the word is unchanged.
- R7: In data mode every input word is ignored: no write, no forward, and `cfg_flat` and `mode_o` stay unchanged until reset.
- R8: Immediately after reset, a first word writing 8'h03 to register 0 puts the node into mixed mode for the following word.
- R9: A hop-0 control word whose index is `NUM_REGS` or more causes no write strobe and changes no register.
- R10: The largest hop count, 7, is forwarded as 6, so eight positions in a chain can be addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An incoming word is present this cycle |
| in_word | input | 16 | Incoming serial word |
| smp_in_valid | input | 1 | A converter sample word is present this cycle |
| smp_in_word | input | 16 | Converter sample word |
| wr_strobe | output | 1 | One-cycle register write indication |
| wr_index | output | 3 | Index of the register written |
| wr_data | output | 8 | Data written |
| fwd_valid | output | 1 | A word is forwarded this cycle |
| fwd_word | output | 16 | Forwarded word with hop count reduced |
| smp_out_valid | output | 1 | Outgoing sample word valid |
| smp_out_word | output | 16 | Outgoing sample word |
| mode_o | output | 2 | Current mode: 00 program, 01 data, 11 mixed |
| cfg_flat | output | 8*NUM_REGS | All configuration registers, register i at bits 8*i+7:8*i |

## Verification
The bench builds the router with `NUM_REGS` = 6. This leaves indices 6 and 7 of the 3-bit index field unbacked, so the out-of-range write path can be reached with ordinary words. Every hop count from 1 to 7 is sent back to back. Each mode is entered in turn, with sample words interleaved with control traffic. A second reset checks that data mode is left only through reset, and that mixed mode can be entered by the first write.

// File: rtl/cwr_pkg.sv
// Shared field positions, mode encoding and decode record for the router.
package cwr_pkg;
    localparam int WORD_W  = 16;
    localparam int FLAG_B  = 15;
    localparam int HOP_LO  = 12;
    localparam int HOP_W   = 3;
    localparam int IDX_LO  = 8;
    localparam int IDX_W   = 3;
    localparam int DAT_W   = 8;
    localparam int MAX_REG = 1 << IDX_W;

    typedef enum logic [1:0] {
        MODE_PROG = 2'b00,
        MODE_DATA = 2'b01,
        MODE_MIX  = 2'b11
    } mode_e;

    typedef struct packed {
        logic               write;
        logic               fwd;
        logic [IDX_W-1:0]   idx;
        logic [DAT_W-1:0]   dat;
        logic [WORD_W-1:0]  fwd_word;
    } dec_t;
endpackage

// File: rtl/cwr_decode.sv
// Combinational classifier for one incoming word.
// Decides between a local write, a forward and a discard, from the current mode.
// Assumes the mode is stable for the whole cycle (it comes from a register).
module cwr_decode
    import cwr_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  mode_e             mode,
    output dec_t              dec
);
    localparam int CMP_W = IDX_W + 1;
    localparam logic [CMP_W-1:0] NREG_C = CMP_W'(NUM_REGS);

    logic             accept;
    logic [HOP_W-1:0] hop;
    logic [IDX_W-1:0] idx;
    logic             local_hit;

    // Classify the word and build the forwarded copy with a reduced hop count.
    always_comb begin
        accept    = in_valid && ((mode == MODE_PROG) ||
                                 ((mode == MODE_MIX) && in_word[FLAG_B]));
        hop       = in_word[HOP_LO +: HOP_W];
        idx       = in_word[IDX_LO +: IDX_W];
        local_hit = (hop == '0);
        dec.write = accept && local_hit && ({1'b0, idx} < NREG_C);
        dec.fwd   = accept && !local_hit;
        dec.idx   = idx;
        dec.dat   = in_word[DAT_W-1:0];
        dec.fwd_word = in_word;
        dec.fwd_word[HOP_LO +: HOP_W] = hop - HOP_W'(1);
    end
endmodule

// File: rtl/cwr_regbank.sv
// Configuration register bank with the mode derived from register 0.
// Assumes the decoder already suppresses writes in data mode; the
// assertions here catch any write that slips through.
module cwr_regbank
    import cwr_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DAT_W-1:0]          wr_dat,
    output logic [NUM_REGS*DAT_W-1:0] cfg_flat,
    output mode_e                     mode
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [DAT_W-1:0] q;
        // Hold one register; load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                q <= wr_dat;
        end
        assign cfg_flat[g*DAT_W +: DAT_W] = q;
    end

    // Decode the mode bits held in register 0.
    always_comb begin
        if (!cfg_flat[0])
            mode = MODE_PROG;
        else if (cfg_flat[1])
            mode = MODE_MIX;
        else
            mode = MODE_DATA;
    end

    assert_data_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DATA) |=> $stable(cfg_flat));
    assert_data_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DATA) |=> (mode == MODE_DATA));
endmodule

// File: rtl/cwr_outstage.sv
// Output registers: write strobe, forwarded word and sample path.
// Every output appears one clock after its cause.
// Sample words lose their top bit in mixed mode.
module cwr_outstage
    import cwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec,
    input  mode_e             mode,
    input  logic              smp_in_valid,
    input  logic [WORD_W-1:0] smp_in_word,
    output logic              wr_strobe,
    output logic [IDX_W-1:0]  wr_index,
    output logic [DAT_W-1:0]  wr_data,
    output logic              fwd_valid,
    output logic [WORD_W-1:0] fwd_word,
    output logic              smp_out_valid,
    output logic [WORD_W-1:0] smp_out_word
);
    logic [WORD_W-1:0] smp_mark;

    // Clear the flag bit of a sample while mixed mode is active.
    always_comb begin
        smp_mark = smp_in_word;
        if (mode == MODE_MIX)
            smp_mark[FLAG_B] = 1'b0;
    end

    // Register the write strobe, the forwarded word and the sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_strobe     <= 1'b0;
            wr_index      <= '0;
            wr_data       <= '0;
            fwd_valid     <= 1'b0;
            fwd_word      <= '0;
            smp_out_valid <= 1'b0;
            smp_out_word  <= '0;
        end else begin
            wr_strobe     <= dec.write;
            wr_index      <= dec.idx;
            wr_data       <= dec.dat;
            fwd_valid     <= dec.fwd;
            fwd_word      <= dec.fwd_word;
            smp_out_valid <= smp_in_valid;
            smp_out_word  <= smp_mark;
        end
    end

    assert_sample_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_in_valid && mode == MODE_MIX) |=> (smp_out_valid && !smp_out_word[FLAG_B]));
    assert_write_xor_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_strobe, fwd_valid}));
endmodule

// File: rtl/cascade_ctl_router.sv
// Top of the daisy-chain control word router.
// Composes the decoder, the register bank and the output stage.
// Assumes at most one incoming word and one sample word per cycle.
module cascade_ctl_router
    import cwr_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [15:0]               in_word,
    input  logic                      smp_in_valid,
    input  logic [15:0]               smp_in_word,
    output logic                      wr_strobe,
    output logic [2:0]                wr_index,
    output logic [7:0]                wr_data,
    output logic                      fwd_valid,
    output logic [15:0]               fwd_word,
    output logic                      smp_out_valid,
    output logic [15:0]               smp_out_word,
    output logic [1:0]                mode_o,
    output logic [NUM_REGS*8-1:0]     cfg_flat
);
    localparam int CMP_W = IDX_W + 1;
    localparam logic [CMP_W-1:0] NREG_C = CMP_W'(NUM_REGS);

    dec_t  dec;
    mode_e mode;

    cwr_decode #(.NUM_REGS(NUM_REGS)) u_decode (
        .in_valid (in_valid),
        .in_word  (in_word),
        .mode     (mode),
        .dec      (dec)
    );

    cwr_regbank #(.NUM_REGS(NUM_REGS)) u_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec.write),
        .wr_idx   (dec.idx),
        .wr_dat   (dec.dat),
        .cfg_flat (cfg_flat),
        .mode     (mode)
    );

    cwr_outstage u_out (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec           (dec),
        .mode          (mode),
        .smp_in_valid  (smp_in_valid),
        .smp_in_word   (smp_in_word),
        .wr_strobe     (wr_strobe),
        .wr_index      (wr_index),
        .wr_data       (wr_data),
        .fwd_valid     (fwd_valid),
        .fwd_word      (fwd_word),
        .smp_out_valid (smp_out_valid),
        .smp_out_word  (smp_out_word)
    );

    assign mode_o = mode;

    assert_fwd_hop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (mode == MODE_PROG || (mode == MODE_MIX && in_word[15])) &&
         in_word[14:12] != 3'd0)
        |=> (fwd_valid && !wr_strobe &&
             fwd_word[14:12] == $past(in_word[14:12]) - 3'd1 &&
             fwd_word[15] == $past(in_word[15]) &&
             fwd_word[11:0] == $past(in_word[11:0])));
    assert_mixed_data_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == MODE_MIX && !in_word[15]) |=> (!wr_strobe && !fwd_valid));
    assert_data_mode_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DATA) |=> (!wr_strobe && !fwd_valid));
    assert_index_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> ({1'b0, wr_index} < NREG_C));
endmodule

// File: tb/tb_cascade_ctl_router.sv
`timescale 1ns/1ps
module tb_cascade_ctl_router;
    localparam int NREG = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [15:0]       in_word = '0;
    logic              smp_in_valid = 1'b0;
    logic [15:0]       smp_in_word = '0;
    logic              wr_strobe, fwd_valid, smp_out_valid;
    logic [2:0]        wr_index;
    logic [7:0]        wr_data;
    logic [15:0]       fwd_word, smp_out_word;
    logic [1:0]        mode_o;
    logic [NREG*8-1:0] cfg_flat;

    cascade_ctl_router #(.NUM_REGS(NREG)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .smp_in_valid(smp_in_valid), .smp_in_word(smp_in_word),
        .wr_strobe(wr_strobe), .wr_index(wr_index), .wr_data(wr_data),
        .fwd_valid(fwd_valid), .fwd_word(fwd_word),
        .smp_out_valid(smp_out_valid), .smp_out_word(smp_out_word),
        .mode_o(mode_o), .cfg_flat(cfg_flat)
    );

    int total = 0;
    int bad = 0;
    logic [15:0] wr_q[$];
    logic [15:0] fwd_q[$];
    logic [15:0] smp_q[$];
    logic [7:0]  mregs [NREG];

    function automatic logic [1:0] model_mode();
        if (!mregs[0][0]) return 2'b00;
        return mregs[0][1] ? 2'b11 : 2'b01;
    endfunction

    function automatic logic [NREG*8-1:0] model_cfg();
        logic [NREG*8-1:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = mregs[i];
        return v;
    endfunction

    function automatic logic [15:0] cw(bit flag, int hop, int idx, int dat);
        return {flag, 3'(hop), 1'b0, 3'(idx), 8'(dat)};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: presents one cycle of stimulus and queues the expected results.
    task automatic drive(bit wv, logic [15:0] w, bit sv, logic [15:0] s);
        logic [1:0] m;
        @(negedge clk);
        m = model_mode();
        if (sv) smp_q.push_back(m == 2'b11 ? {1'b0, s[14:0]} : s);
        if (wv && m != 2'b01 && (m == 2'b00 || w[15])) begin
            if (w[14:12] == 3'd0) begin
                if (int'(w[10:8]) < NREG) begin
                    wr_q.push_back({5'b0, w[10:8], w[7:0]});
                    mregs[w[10:8]] = w[7:0];
                end
            end else begin
                fwd_q.push_back({w[15], w[14:12] - 3'd1, w[11:0]});
            end
        end
        in_valid = wv; in_word = w; smp_in_valid = sv; smp_in_word = s;
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0; smp_in_valid = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; smp_in_valid = 1'b0;
        for (int i = 0; i < NREG; i++) mregs[i] = 8'h00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops the expected items and compares them with the outputs.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (wr_strobe) begin
                if (wr_q.size() == 0) check("R2 unexpected write", {wr_index, wr_data}, 0);
                else check("R2 write", {5'b0, wr_index, wr_data}, wr_q.pop_front());
            end
            if (fwd_valid) begin
                if (fwd_q.size() == 0) check("R3 unexpected forward", fwd_word, 0);
                else check("R3 forward", fwd_word, fwd_q.pop_front());
            end
            if (smp_out_valid) begin
                if (smp_q.size() == 0) check("R6 unexpected sample", smp_out_word, 0);
                else check("R6 sample", smp_out_word, smp_q.pop_front());
            end
        end
    end

    bit finished = 1'b0;
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk); #2;
        // R1: reset state
        check("R1 mode", mode_o, 2'b00);
        check("R1 cfg", cfg_flat, '0);
        check("R1 outputs", {wr_strobe, fwd_valid, smp_out_valid}, 3'b000);

        // R2: local writes in program mode, flag bit irrelevant
        drive(1, cw(0, 0, 1, 8'hA5), 0, 0);
        drive(1, cw(0, 0, 5, 8'h3C), 0, 0);
        drive(1, cw(1, 0, 2, 8'h5A), 1, 16'hF00D);
        idle(2);
        check("R2 cfg", cfg_flat, model_cfg());

        // R3 / R10: every hop count back to back, hop 7 leaves as 6
        for (int h = 1; h < 8; h++) drive(1, cw(h[0], h, h, 8'h11 * h) | 16'h0800, 0, 0);
        idle(2);
        check("R3 cfg unchanged", cfg_flat, model_cfg());

        // R9: indices beyond the bank
        drive(1, cw(0, 0, 6, 8'hEE), 0, 0);
        drive(1, cw(0, 0, 7, 8'hDD), 0, 0);
        idle(2);
        check("R9 cfg unchanged", cfg_flat, model_cfg());

        // R4: bit 1 alone keeps program mode
        drive(1, cw(0, 0, 0, 8'h02), 0, 0);
        idle(2);
        check("R4 program", mode_o, 2'b00);
        drive(0, 0, 1, 16'h8123);
        // R4: enter mixed mode
        drive(1, cw(0, 0, 0, 8'h03), 0, 0);
        idle(2);
        check("R4 mixed", mode_o, 2'b11);

        // R5: flag clear is ignored, flag set is control; R6 sample marking
        drive(1, cw(0, 0, 3, 8'h77), 1, 16'hFFFF);
        drive(1, cw(0, 2, 3, 8'h66), 1, 16'h8001);
        idle(2);
        check("R5 cfg unchanged", cfg_flat, model_cfg());
        drive(1, cw(1, 0, 3, 8'h99), 1, 16'h7FFE);
        drive(1, cw(1, 3, 4, 8'h42), 0, 0);
        idle(2);
        check("R5 cfg", cfg_flat, model_cfg());

        // R7: enter data mode, then everything is ignored
        drive(1, cw(1, 0, 0, 8'h01), 0, 0);
        idle(2);
        check("R7 mode", mode_o, 2'b01);
        drive(1, cw(0, 0, 1, 8'h00), 1, 16'h9999);
        drive(1, cw(1, 0, 0, 8'h00), 0, 0);
        drive(1, cw(1, 2, 1, 8'h12), 0, 0);
        idle(3);
        check("R7 cfg frozen", cfg_flat, model_cfg());
        check("R7 mode held", mode_o, 2'b01);

        // R1 / R8: reset restores program mode; first write selects mixed
        do_reset();
        @(negedge clk); #2;
        check("R1 after reset mode", mode_o, 2'b00);
        check("R1 after reset cfg", cfg_flat, '0);
        drive(1, cw(0, 0, 0, 8'h03), 0, 0);
        drive(1, cw(0, 0, 4, 8'h55), 1, 16'hC0DE);
        drive(1, cw(1, 0, 4, 8'hAA), 0, 0);
        idle(2);
        check("R8 mode", mode_o, 2'b11);
        check("R8 cfg", cfg_flat, model_cfg());

        idle(3);
        check("R2 queue drained", wr_q.size(), 0);
        check("R3 queue drained", fwd_q.size(), 0);
        check("R6 queue drained", smp_q.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule